// File: doc/BRIEF.md
# Charge-Pump Boost Acquisition Controller

This block sets the charge-pump current for one or more phase-locked loops while they acquire a new frequency. Each loop has its own lane. A lane sees the up and down pulses of its phase-frequency detector, a lock indication, a boost-enable bit, a programmed current code, and a strobe. The strobe marks that a new divider value was written, which starts a new acquisition. The lane produces the current drive code for the analog charge pump and a flag that shows when the boost is active.

When an acquisition starts with boost enabled, the lane adds a fixed boost step on top of the programmed code. It then tracks the sign of the phase error. The sign comes from the most recent cycle that had exactly one of the two detector pulses. The lane counts each flip of that sign. The boost ends when the reversal count reaches its limit (two by default) or when lock is reported, whichever comes first. The drive then falls back to the programmed code.

The lanes are fully independent. A typical chip uses two of them: one for the intermediate-frequency loop and one for the radio-frequency loop. The analog charge pump and the loop filter are outside this block.

Top module: `cp_boost_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no acquisition, every lane shows turbo_on = 0 and a drive code equal to its programmed code.
- R2: A cycle with acq_start = 1 and turbo_en = 1 sets turbo_on on the next clock edge. While turbo_on is 1, the lane's drive equals its code plus BOOST_CODE, which is 7 with the default 3-bit code. This addition makes the boost current add to the programmed current and not replace it.
- R3: A cycle with acq_start = 1 and turbo_en = 0 leaves turbo_on at 0 on the next edge. The lane then stays unboosted whatever detector pulses arrive, until the next acquisition.
- R4: While boosted, a cycle with lock_det = 1 and no acq_start ends the boost on the next edge.
- R5: Phase sign is lead for up = 1, dn = 0 and lag for up = 0, dn = 1. The boost ends on the edge that samples the second change of sign, counting lead-to-lag and lag-to-lead alike. The first change does not end it.
- R6: Cycles with both pulses or with neither pulse do not change the tracked sign. Repeated pulses of the same sign count as no reversal.
- R7: An acquisition strobe during a boost restarts it. The reversal count and the tracked sign are cleared, so two fresh reversals are needed again.
- R8: Lanes are independent. Stimulus on one lane never changes turbo_on or drive on another.
- R9: The drive follows a change of cp_code in the same cycle, both with and without boost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfd_up | input | LOOPS | Detector up pulse per lane (phase lead) |
| pfd_dn | input | LOOPS | Detector down pulse per lane (phase lag) |
| lock_det | input | LOOPS | Lock indication per lane |
| turbo_en | input | LOOPS | Boost enable per lane, sampled at acquisition start |
| acq_start | input | LOOPS | New divider value written; starts an acquisition |
| cp_code | input | LOOPS*CODE_W | Programmed current code, lane i at bits [i*CODE_W +: CODE_W] |
| cp_drive | output | LOOPS*(CODE_W+1) | Current drive code, lane i at bits [i*(CODE_W+1) +: CODE_W+1] |
| turbo_on | output | LOOPS | Boost active per lane |

## Verification
The boost exit is tried with several sign sequences: a clean lead-lag-lead sequence, long runs of one sign, and both-or-neither cycles placed between flips. Together these show whether the design counts genuine sign changes or only raw pulse edges. Lock-terminated and restart-during-boost sequences separate the two exit paths from the restart clearing. Runs with boost disabled, and stimulus applied to only one lane, show that nothing re-arms without an enabled acquisition and that nothing leaks between lanes. A long run of random pulses, locks and strobes is then compared every cycle against a behavioural model. Code changes during that run cover the live pass-through of the drive.

// File: rtl/cpb_pkg.sv
package cpb_pkg;

   typedef enum logic [1:0] {
      PH_NONE = 2'd0,
      PH_LEAD = 2'd1,
      PH_LAG  = 2'd2
   } phase_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_BOOST = 1'b1
   } boost_st_e;

   function automatic phase_e classify_phase(input logic up, input logic dn);
      if (up && !dn)      return PH_LEAD;
      else if (dn && !up) return PH_LAG;
      else                return PH_NONE;
   endfunction

endpackage

// File: rtl/cpb_phase_sense.sv
module cpb_phase_sense
   import cpb_pkg::*;
(
   input  logic   up_i,
   input  logic   dn_i,
   output phase_e phase_o
);

   always_comb begin
      phase_o = classify_phase(up_i, dn_i);
   end

endmodule

// File: rtl/cpb_rev_track.sv
module cpb_rev_track
   import cpb_pkg::*;
#(
   parameter int REV_LIMIT = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   clear_i,
   input  phase_e phase_i,
   output logic   limit_hit_o
);

   localparam int CNT_W = (REV_LIMIT > 1) ? $clog2(REV_LIMIT) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(REV_LIMIT - 1);

   logic             seen_q;
   logic             lead_q;
   logic [CNT_W-1:0] cnt_q;
   logic             has_sign;
   logic             sign_lead;
   logic             flip;

   always_comb begin
      has_sign    = (phase_i != PH_NONE);
      sign_lead   = (phase_i == PH_LEAD);
      flip        = has_sign && seen_q && (sign_lead != lead_q);
      limit_hit_o = flip && (cnt_q == LAST_IDX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         lead_q <= 1'b0;
         cnt_q  <= '0;
      end else if (clear_i) begin
         seen_q <= 1'b0;
         lead_q <= 1'b0;
         cnt_q  <= '0;
      end else if (has_sign) begin
         seen_q <= 1'b1;
         lead_q <= sign_lead;
         if (flip && (cnt_q != LAST_IDX)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/cpb_boost_fsm.sv
module cpb_boost_fsm
   import cpb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic acq_i,
   input  logic en_i,
   input  logic lock_i,
   input  logic limit_hit_i,
   output logic boost_o,
   output logic clear_o
);

   boost_st_e state_q;
   boost_st_e state_d;

   always_comb begin
      state_d = state_q;
      if (acq_i) begin
         state_d = en_i ? ST_BOOST : ST_IDLE;
      end else if ((state_q == ST_BOOST) && (lock_i || limit_hit_i)) begin
         state_d = ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      boost_o = (state_q == ST_BOOST);
      clear_o = acq_i || (state_q == ST_IDLE);
   end

endmodule

// File: rtl/cpb_drive_mix.sv
module cpb_drive_mix #(
   parameter int CODE_W     = 3,
   parameter int BOOST_CODE = 7
) (
   input  logic              boost_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [CODE_W:0]   drive_o
);

   localparam logic [CODE_W:0] BOOST_EXT = (CODE_W + 1)'(BOOST_CODE);

   always_comb begin
      drive_o = {1'b0, code_i};
      if (boost_i) begin
         drive_o = {1'b0, code_i} + BOOST_EXT;
      end
   end

endmodule

// File: rtl/cp_boost_ctrl.sv
module cp_boost_ctrl
   import cpb_pkg::*;
#(
   parameter int LOOPS      = 2,
   parameter int CODE_W     = 3,
   parameter int BOOST_CODE = (1 << CODE_W) - 1,
   parameter int REV_LIMIT  = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [LOOPS-1:0]           pfd_up,
   input  logic [LOOPS-1:0]           pfd_dn,
   input  logic [LOOPS-1:0]           lock_det,
   input  logic [LOOPS-1:0]           turbo_en,
   input  logic [LOOPS-1:0]           acq_start,
   input  logic [LOOPS*CODE_W-1:0]    cp_code,
   output logic [LOOPS*(CODE_W+1)-1:0] cp_drive,
   output logic [LOOPS-1:0]           turbo_on
);

   localparam int DRV_W = CODE_W + 1;

   if (LOOPS < 1) begin : g_bad_loops
      $error("cp_boost_ctrl: LOOPS must be at least 1");
   end
   if (CODE_W < 1) begin : g_bad_code
      $error("cp_boost_ctrl: CODE_W must be at least 1");
   end
   if ((BOOST_CODE < 0) || (BOOST_CODE >= (1 << CODE_W))) begin : g_bad_boost
      $error("cp_boost_ctrl: BOOST_CODE must fit in CODE_W bits");
   end
   if (REV_LIMIT < 1) begin : g_bad_rev
      $error("cp_boost_ctrl: REV_LIMIT must be at least 1");
   end

   for (genvar i = 0; i < LOOPS; i++) begin : g_lane
      phase_e ph;
      logic   limit_hit;
      logic   boost;
      logic   clear;

      cpb_phase_sense u_sense (
         .up_i    (pfd_up[i]),
         .dn_i    (pfd_dn[i]),
         .phase_o (ph)
      );

      cpb_rev_track #(.REV_LIMIT(REV_LIMIT)) u_rev (
         .clk         (clk),
         .rst_n       (rst_n),
         .clear_i     (clear),
         .phase_i     (ph),
         .limit_hit_o (limit_hit)
      );

      cpb_boost_fsm u_fsm (
         .clk         (clk),
         .rst_n       (rst_n),
         .acq_i       (acq_start[i]),
         .en_i        (turbo_en[i]),
         .lock_i      (lock_det[i]),
         .limit_hit_i (limit_hit),
         .boost_o     (boost),
         .clear_o     (clear)
      );

      cpb_drive_mix #(.CODE_W(CODE_W), .BOOST_CODE(BOOST_CODE)) u_mix (
         .boost_i (boost),
         .code_i  (cp_code[i*CODE_W +: CODE_W]),
         .drive_o (cp_drive[i*DRV_W +: DRV_W])
      );

      assign turbo_on[i] = boost;
   end

endmodule

// File: rtl/cp_boost_ctrl_chk.sv
module cp_boost_ctrl_chk #(
   parameter int LOOPS = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LOOPS-1:0] pfd_up,
   input logic [LOOPS-1:0] pfd_dn,
   input logic [LOOPS-1:0] lock_det,
   input logic [LOOPS-1:0] turbo_en,
   input logic [LOOPS-1:0] acq_start,
   input logic [LOOPS-1:0] turbo_on
);

   for (genvar i = 0; i < LOOPS; i++) begin : g_chk
      // R2
      arm_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (acq_start[i] && turbo_en[i]) |=> turbo_on[i]);

      // R3
      no_arm_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (acq_start[i] && !turbo_en[i]) |=> !turbo_on[i]);

      // R3
      rise_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(turbo_on[i]) |-> $past(acq_start[i] && turbo_en[i]));

      // R3
      stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!turbo_on[i] && !acq_start[i]) |=> !turbo_on[i]);

      // R4
      lock_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (turbo_on[i] && lock_det[i] && !acq_start[i]) |=> !turbo_on[i]);

      // R6
      no_sign_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (turbo_on[i] && !lock_det[i] && !acq_start[i] && (pfd_up[i] == pfd_dn[i]))
         |=> turbo_on[i]);
   end

endmodule

bind cp_boost_ctrl cp_boost_ctrl_chk #(.LOOPS(LOOPS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pfd_up    (pfd_up),
   .pfd_dn    (pfd_dn),
   .lock_det  (lock_det),
   .turbo_en  (turbo_en),
   .acq_start (acq_start),
   .turbo_on  (turbo_on)
);

// File: tb/sim_cp_boost_ctrl.sv
module sim_cp_boost_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int L     = 2;
   localparam int W     = 3;
   localparam int BOOST = 7;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [L-1:0]     up = '0, dn = '0, lk = '0, en = '0, acq = '0;
   logic [L*W-1:0]   code = '0;
   logic [L*(W+1)-1:0] drive;
   logic [L-1:0]     ton;

   int errors = 0;
   int checks = 0;
   string req = "R1";

   int m_on[L];
   int m_seen[L];
   int m_lead[L];
   int m_rev[L];

   always #(CLK_PERIOD/2) clk = ~clk;

   cp_boost_ctrl #(.LOOPS(L), .CODE_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .pfd_up(up), .pfd_dn(dn), .lock_det(lk),
      .turbo_en(en), .acq_start(acq), .cp_code(code), .cp_drive(drive), .turbo_on(ton)
   );

   // behavioural reference, updated on each rising edge
   always @(posedge clk) begin
      for (int i = 0; i < L; i++) begin : m_lane
         int s;
         if (!rst_n) begin
            m_on[i] = 0; m_seen[i] = 0; m_lead[i] = 0; m_rev[i] = 0;
         end else if (acq[i]) begin
            m_on[i] = en[i] ? 1 : 0; m_seen[i] = 0; m_rev[i] = 0;
         end else if (m_on[i] == 1) begin
            s = (up[i] && !dn[i]) ? 1 : ((dn[i] && !up[i]) ? 2 : 0);
            if (s != 0) begin
               if (m_seen[i] == 1 && ((s == 1) != (m_lead[i] == 1))) m_rev[i]++;
               m_seen[i] = 1;
               m_lead[i] = (s == 1) ? 1 : 0;
            end
            if (lk[i] || m_rev[i] >= 2) begin
               m_on[i] = 0; m_seen[i] = 0; m_rev[i] = 0;
            end
         end
      end
   end

   task automatic compare();
      for (int i = 0; i < L; i++) begin
         int exp_d;
         int act_d;
         exp_d = int'(code[i*W +: W]) + ((m_on[i] == 1) ? BOOST : 0);
         act_d = int'(drive[i*(W+1) +: (W+1)]);
         checks++;
         if (int'(ton[i]) != m_on[i]) begin
            errors++;
            $display("FAIL %s lane %0d turbo_on act=%0d exp=%0d t=%0t", req, i, ton[i], m_on[i], $time);
         end
         checks++;
         if (act_d != exp_d) begin
            errors++;
            $display("FAIL %s lane %0d drive act=%0d exp=%0d t=%0t", req, i, act_d, exp_d, $time);
         end
      end
   endtask

   task automatic tick(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         compare();
      end
   endtask

   // drive one lane for one cycle, then return its pulses to idle
   task automatic drv(int lp, bit u, bit d, bit l, bit a);
      up[lp] = u; dn[lp] = d; lk[lp] = l; acq[lp] = a;
      tick(1);
      up[lp] = 1'b0; dn[lp] = 1'b0; lk[lp] = 1'b0; acq[lp] = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      summary();
      $finish;
   end

   initial begin
      code = {3'd2, 3'd5};
      // R1: reset state
      req = "R1";
      tick(3);
      rst_n = 1'b1;
      tick(3);

      // R2: enabled acquisition on lane 0 adds the boost
      req = "R2";
      en = 2'b11;
      drv(0, 0, 0, 0, 1);
      tick(3);

      // R5: lead, lead, lag (1st flip), idle, lag, lead (2nd flip ends)
      req = "R5";
      drv(0, 1, 0, 0, 0); drv(0, 1, 0, 0, 0); drv(0, 0, 1, 0, 0);
      tick(1);
      drv(0, 0, 1, 0, 0); drv(0, 1, 0, 0, 0);
      tick(2);

      // R6: both / neither cycles between flips do not count
      req = "R6";
      drv(0, 0, 0, 0, 1);
      drv(0, 1, 0, 0, 0); drv(0, 1, 1, 0, 0); drv(0, 0, 0, 0, 0);
      drv(0, 1, 0, 0, 0); drv(0, 1, 0, 0, 0); drv(0, 1, 1, 0, 0);
      drv(0, 0, 1, 0, 0); drv(0, 1, 1, 0, 0); drv(0, 0, 1, 0, 0);
      drv(0, 1, 1, 0, 0); tick(1);
      drv(0, 1, 0, 0, 0);
      tick(2);

      // R7: restart during boost clears the reversal count
      req = "R7";
      drv(0, 0, 0, 0, 1);
      drv(0, 1, 0, 0, 0); drv(0, 0, 1, 0, 0);
      drv(0, 0, 0, 0, 1);
      drv(0, 1, 0, 0, 0); drv(0, 0, 1, 0, 0);
      tick(2);
      drv(0, 1, 0, 0, 0);
      tick(2);

      // R4: lock ends the boost
      req = "R4";
      drv(0, 0, 0, 0, 1);
      drv(0, 1, 0, 0, 0);
      drv(0, 0, 0, 1, 0);
      tick(2);

      // R3: disabled acquisition, pulses cannot re-arm
      req = "R3";
      en[0] = 1'b0;
      drv(0, 0, 0, 0, 1);
      for (int k = 0; k < 6; k++) drv(0, k[0], !k[0], 0, 0);
      tick(2);
      en[0] = 1'b1;

      // R8: lane 1 boosted while lane 0 stays idle, then lock on lane 0 only
      req = "R8";
      drv(1, 0, 0, 0, 1);
      drv(0, 1, 0, 1, 0);
      drv(0, 0, 1, 0, 0);
      tick(2);

      // R9: code changes while lane 1 is boosted and lane 0 is idle
      req = "R9";
      code = {3'd0, 3'd7};
      tick(1);
      code = {3'd7, 3'd0};
      tick(1);
      drv(1, 0, 0, 1, 0);
      code = {3'd4, 3'd1};
      tick(2);

      // R5: random mix compared against the model every cycle
      req = "R5";
      for (int k = 0; k < 600; k++) begin
         up   = L'($urandom);
         dn   = L'($urandom);
         lk   = ($urandom_range(0, 15) == 0) ? L'($urandom) : '0;
         acq  = ($urandom_range(0, 9) == 0) ? L'($urandom) : '0;
         en   = L'($urandom) | L'($urandom);
         if ($urandom_range(0, 7) == 0) code = (L*W)'($urandom);
         tick(1);
      end
      up = '0; dn = '0; lk = '0; acq = '0;
      tick(2);

      summary();
      $finish;
   end

endmodule